// File: doc/BRIEF.md
# Full-Bridge Dead-Time Sequencer

This block is the digital sequencer for a four-switch full bridge. A counter climbs and falls like a triangle wave between one third and two thirds of its full-scale count. The counter's direction picks which diagonal pair of switches conducts. While the ramp rises, the first leg's low switch and the second leg's high switch conduct. While it falls, the second leg's low switch and the first leg's high switch conduct. Whenever the wanted switch pattern changes, every gate drops in that same cycle. The new pattern only appears after a programmable dead time of all-low cycles.

After power-good, and after any ramp hold, the ramp restarts from zero. While it climbs to the lower threshold, both low-side switches are on and both high-side switches are off, so the floating high-side supplies can charge. A shutdown trip latches a fault with all gates low. Only a supply drop below the falling lockout level, followed by a rise above the rising level, clears it. The supply status arrives as two flags that together form a hysteresis band.

The parameters set the counter width, the ramp step per clock and the dead-time length. An option halves the dead time.

Top module: `fb_deadtime_seq`

## Requirements
- R1: In steady oscillation with the default parameters (8-bit ramp, step 1, dead time 8 cycles), each diagonal is on for 77 consecutive cycles per half period. That is the lower threshold (full scale / 3 = 85) divided by the step, minus the dead time. Both diagonals get equal on-time.
- R2: While the ramp rises from the lower threshold to the upper threshold (twice the lower threshold), the outputs are leg1_low and leg2_high. While it falls back to the lower threshold, the outputs are leg2_low and leg1_high.
- R3: In the cycle where the wanted pattern changes, all four gates go low. They stay low for exactly the dead time in cycles before the new pattern appears. The dead time is DT_CYC, or DT_CYC/2 when DT_HALF is 1.
- R4: After leaving lockout, and after a hold, the ramp restarts from zero. Until it reaches the lower threshold, both low gates are high and both high gates are low, after the dead time of R3.
- R5: While ramp_hold is asserted, the ramp is discharged to zero and both high gates are low from the next cycle. On release, the ramp climbs again from zero.
- R6: trip_in, when sampled high outside lockout, latches a fault. In the fault, all gates are low. The fault persists until vlow_fall puts the block into lockout and vgood_rise later brings it out. trip_in is ignored while in lockout.
- R7: After reset, and while in lockout, all four gates are low.
- R8: Lockout is left only when vgood_rise is high and entered only when vlow_fall is high. With both flags low, the block stays in its present state.
- R9: leg1_low and leg1_high are never high together, and neither are leg2_low and leg2_high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, enters lockout |
| vgood_rise | input | 1 | Supply is above the rising lockout threshold |
| vlow_fall | input | 1 | Supply is below the falling lockout threshold |
| ramp_hold | input | 1 | External request to discharge and hold the ramp |
| trip_in | input | 1 | Shutdown trip, latched as a fault |
| leg1_low | output | 1 | Leg 1 low-side gate enable |
| leg1_high | output | 1 | Leg 1 high-side gate enable |
| leg2_low | output | 1 | Leg 2 low-side gate enable |
| leg2_high | output | 1 | Leg 2 high-side gate enable |

## Verification
The bench targets each change of switch pattern: precharge to first diagonal, diagonal to diagonal, diagonal to precharge on a hold, and pattern to all-low on a trip. A design that delays the turn-off by a cycle, or that counts the dead time one cycle short or long, diverges from the reference model at that edge. The bench also asserts a trip and then raises only the rising flag. A fault latch that cleared on the rising flag alone would restart the bridge there. A trip issued during lockout must not stop the later start-up. The bench measures the on-time of each diagonal in steady state, which exposes an off-by-one in either turn-around comparison as unequal half periods.

// File: rtl/fb_seq_pkg.sv
package fb_seq_pkg;

   typedef enum logic [1:0] {
      DG_OFF = 2'd0,
      DG_PRE = 2'd1,
      DG_A   = 2'd2,
      DG_B   = 2'd3
   } diag_e;

   typedef struct packed {
      logic l1;
      logic h1;
      logic l2;
      logic h2;
   } gate_t;

   function automatic gate_t diag_gates(input diag_e d);
      gate_t g;
      g = '0;
      case (d)
         DG_PRE:  begin g.l1 = 1'b1; g.l2 = 1'b1; end
         DG_A:    begin g.l1 = 1'b1; g.h2 = 1'b1; end
         DG_B:    begin g.l2 = 1'b1; g.h1 = 1'b1; end
         default: g = '0;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/fb_supply_guard.sv
module fb_supply_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic vgood_rise,
   input  logic vlow_fall,
   input  logic trip_in,
   output logic uv_q,
   output logic fault_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uv_q    <= 1'b1;
         fault_q <= 1'b0;
      end else begin
         if (uv_q) begin
            if (vgood_rise) uv_q <= 1'b0;
         end else if (vlow_fall) begin
            uv_q <= 1'b1;
         end
         if (uv_q)         fault_q <= 1'b0;
         else if (trip_in) fault_q <= 1'b1;
      end
   end

endmodule

// File: rtl/fb_ramp_gen.sv
module fb_ramp_gen
   import fb_seq_pkg::*;
#(
   parameter int RAMP_W = 8,
   parameter int STEP   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop,
   input  logic              hold,
   output logic [RAMP_W-1:0] ramp_q,
   output diag_e             want
);

   localparam int FULL = 1 << RAMP_W;
   localparam int LOW  = FULL / 3;
   localparam int HIGH = 2 * LOW;
   localparam logic [RAMP_W-1:0] LOW_V  = RAMP_W'(LOW);
   localparam logic [RAMP_W-1:0] HIGH_V = RAMP_W'(HIGH);
   localparam logic [RAMP_W-1:0] STEP_V = RAMP_W'(STEP);

   logic up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ramp_q <= '0;
         up_q   <= 1'b1;
      end else if (stop || hold) begin
         ramp_q <= '0;
         up_q   <= 1'b1;
      end else if (up_q) begin
         if (ramp_q >= HIGH_V) begin
            up_q   <= 1'b0;
            ramp_q <= ramp_q - STEP_V;
         end else begin
            ramp_q <= ramp_q + STEP_V;
         end
      end else begin
         if (ramp_q <= LOW_V) begin
            up_q   <= 1'b1;
            ramp_q <= ramp_q + STEP_V;
         end else begin
            ramp_q <= ramp_q - STEP_V;
         end
      end
   end

   always_comb begin
      if (stop)                         want = DG_OFF;
      else if (up_q && ramp_q < LOW_V)  want = DG_PRE;
      else if (up_q)                    want = DG_A;
      else                              want = DG_B;
   end

endmodule

// File: rtl/fb_dead_gap.sv
module fb_dead_gap
   import fb_seq_pkg::*;
#(
   parameter int DEAD = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  diag_e want,
   output gate_t gates
);

   diag_e held_q;
   logic  quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              held_q <= DG_OFF;
      else if (want != held_q) held_q <= want;
   end

   generate
      if (DEAD == 1) begin : g_single
         assign quiet = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DEAD);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (want != held_q) cnt_q <= CW'(DEAD - 1);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign quiet = (cnt_q == '0);
      end
   endgenerate

   assign gates = (want == held_q && quiet) ? diag_gates(held_q) : '0;

endmodule

// File: rtl/fb_deadtime_seq.sv
module fb_deadtime_seq
   import fb_seq_pkg::*;
#(
   parameter int RAMP_W  = 8,
   parameter int STEP    = 1,
   parameter int DT_CYC  = 8,
   parameter bit DT_HALF = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vgood_rise,
   input  logic vlow_fall,
   input  logic ramp_hold,
   input  logic trip_in,
   output logic leg1_low,
   output logic leg1_high,
   output logic leg2_low,
   output logic leg2_high
);

   localparam int LOW      = (1 << RAMP_W) / 3;
   localparam int DEAD_EFF = DT_HALF ? DT_CYC / 2 : DT_CYC;

   generate
      if (RAMP_W < 4 || RAMP_W > 30) begin : g_bad_width
         $error("RAMP_W must lie between 4 and 30");
      end
      if (STEP < 1 || (LOW % STEP) != 0) begin : g_bad_step
         $error("STEP must be positive and divide the lower threshold");
      end
      if (DEAD_EFF < 1) begin : g_bad_dead
         $error("effective dead time must be at least one cycle");
      end
      if (LOW / STEP <= DEAD_EFF) begin : g_bad_ratio
         $error("half period must exceed the dead time");
      end
   endgenerate

   logic              uv_q;
   logic              fault_q;
   logic [RAMP_W-1:0] ramp_q;
   diag_e             want;
   gate_t             gates;

   fb_supply_guard u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .vgood_rise (vgood_rise),
      .vlow_fall  (vlow_fall),
      .trip_in    (trip_in),
      .uv_q       (uv_q),
      .fault_q    (fault_q)
   );

   fb_ramp_gen #(.RAMP_W(RAMP_W), .STEP(STEP)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .stop   (uv_q | fault_q),
      .hold   (ramp_hold),
      .ramp_q (ramp_q),
      .want   (want)
   );

   fb_dead_gap #(.DEAD(DEAD_EFF)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want),
      .gates (gates)
   );

   assign leg1_low  = gates.l1;
   assign leg1_high = gates.h1;
   assign leg2_low  = gates.l2;
   assign leg2_high = gates.h2;

endmodule

// File: rtl/fb_seq_chk.sv
module fb_seq_chk #(
   parameter int RAMP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vlow_fall,
   input logic              ramp_hold,
   input logic              leg1_low,
   input logic              leg1_high,
   input logic              leg2_low,
   input logic              leg2_high,
   input logic              uv_q,
   input logic              fault_q,
   input logic [RAMP_W-1:0] ramp_q
);

   localparam logic [RAMP_W-1:0] LOW_V = RAMP_W'((1 << RAMP_W) / 3);

   logic all_off;
   assign all_off = !(leg1_low || leg1_high || leg2_low || leg2_high);

   p_leg1_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(leg1_low && leg1_high));

   p_leg2_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(leg2_low && leg2_high));

   p_gap_h1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(leg1_high) |-> $past(all_off));

   p_gap_h2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(leg2_high) |-> $past(all_off));

   p_lockout_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      uv_q |-> all_off);

   p_fault_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> all_off);

   p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && !uv_q) |=> fault_q);

   p_hyst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!uv_q && !vlow_fall) |=> !uv_q);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_hold |=> (!leg1_high && !leg2_high));

   p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_q < LOW_V) |-> (!leg1_high && !leg2_high));

endmodule

bind fb_deadtime_seq fb_seq_chk #(.RAMP_W(RAMP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vlow_fall (vlow_fall),
   .ramp_hold (ramp_hold),
   .leg1_low  (leg1_low),
   .leg1_high (leg1_high),
   .leg2_low  (leg2_low),
   .leg2_high (leg2_high),
   .uv_q      (uv_q),
   .fault_q   (fault_q),
   .ramp_q    (ramp_q)
);

// File: tb/sim_fb_deadtime_seq.sv
`timescale 1ns/1ps
module sim_fb_deadtime_seq;

   localparam int W    = 8;
   localparam int STP  = 1;
   localparam int DEAD = 8;
   localparam int LOW  = (1 << W) / 3;
   localparam int HIGH = 2 * LOW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vgood_rise = 1'b0, vlow_fall = 1'b0, ramp_hold = 1'b0, trip_in = 1'b0;
   logic leg1_low, leg1_high, leg2_low, leg2_high;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fb_deadtime_seq #(.RAMP_W(W), .STEP(STP), .DT_CYC(DEAD), .DT_HALF(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .vgood_rise(vgood_rise), .vlow_fall(vlow_fall),
      .ramp_hold(ramp_hold), .trip_in(trip_in),
      .leg1_low(leg1_low), .leg1_high(leg1_high),
      .leg2_low(leg2_low), .leg2_high(leg2_high));

   // behavioural reference
   int m_uv = 1, m_fault = 0, m_ramp = 0, m_up = 1, m_same = 1000;
   int run1 = 0, run2 = 0, last1 = 0, last2 = 0;

   function int m_want();
      if (m_uv != 0 || m_fault != 0) return 0;
      if (m_up != 0 && m_ramp < LOW) return 1;
      if (m_up != 0) return 2;
      return 3;
   endfunction

   function logic [3:0] m_gates();
      if (m_same < DEAD) return 4'b0000;
      case (m_want())
         1: return 4'b1010;
         2: return 4'b1001;
         3: return 4'b0110;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic m_tick();
      int old_w, nuv, nf;
      old_w = m_want();
      nuv = m_uv;
      if (m_uv != 0) begin if (vgood_rise) nuv = 0; end
      else if (vlow_fall) nuv = 1;
      nf = (m_uv != 0) ? 0 : ((trip_in || m_fault != 0) ? 1 : 0);
      if (m_uv != 0 || m_fault != 0 || ramp_hold) begin
         m_ramp = 0; m_up = 1;
      end else if (m_up != 0) begin
         if (m_ramp >= HIGH) begin m_up = 0; m_ramp = m_ramp - STP; end
         else m_ramp = m_ramp + STP;
      end else begin
         if (m_ramp <= LOW) begin m_up = 1; m_ramp = m_ramp + STP; end
         else m_ramp = m_ramp - STP;
      end
      m_uv = nuv; m_fault = nf;
      if (m_want() == old_w) begin
         if (m_same < 1000) m_same = m_same + 1;
      end else m_same = 0;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [3:0] act, exp;
      string tag;
      act = {leg1_low, leg1_high, leg2_low, leg2_high};
      exp = m_gates();
      if (m_uv != 0)           tag = "R7 lockout";
      else if (m_fault != 0)   tag = "R6 fault";
      else if (ramp_hold)      tag = "R5 hold";
      else if (m_same < DEAD)  tag = "R3 dead gap";
      else if (m_want() == 1)  tag = "R4 precharge";
      else                     tag = "R2 diagonal";
      check(act == exp, tag, int'(act), int'(exp));
      check(!(leg1_low && leg1_high) && !(leg2_low && leg2_high),
            "R9 leg exclusive", int'(act), 0);
      if (leg1_low) run1++; else begin if (run1 > 0) last1 = run1; run1 = 0; end
      if (leg2_low) run2++; else begin if (run2 > 0) last2 = run2; run2 = 0; end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         if (rst_n) m_tick();
         @(negedge clk);
         compare();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      step(4);
      check({leg1_low, leg1_high, leg2_low, leg2_high} == 4'b0, "R7 reset state",
            int'({leg1_low, leg1_high, leg2_low, leg2_high}), 0);
      rst_n = 1'b1;
      step(10);                       // R8: inside the band, still locked out
      check(!leg1_low && !leg2_low, "R8 no start without rising flag",
            int'({leg1_low, leg2_low}), 0);
      vgood_rise = 1'b1; step(2); vgood_rise = 1'b0;
      step(700);                      // R4 precharge then R1/R2 steady run
      check(last1 == LOW / STP - DEAD, "R1 diagonal A on-time", last1, LOW / STP - DEAD);
      check(last2 == LOW / STP - DEAD, "R1 diagonal B on-time", last2, LOW / STP - DEAD);
      step(40);
      ramp_hold = 1'b1; step(30);     // R5 hold
      ramp_hold = 1'b0; step(250);
      trip_in = 1'b1; step(1); trip_in = 1'b0; step(40);   // R6 latch
      vgood_rise = 1'b1; step(20); vgood_rise = 1'b0;      // R6 rising alone: stays off
      check(!leg1_low && !leg2_low, "R6 fault persists on rising flag",
            int'({leg1_low, leg2_low}), 0);
      vlow_fall = 1'b1; step(3); vlow_fall = 1'b0;
      trip_in = 1'b1; step(5); trip_in = 1'b0;             // R6 ignored in lockout
      vgood_rise = 1'b1; step(1); vgood_rise = 1'b0;
      step(150);
      check(leg1_low || leg2_low, "R6 restart after supply recycle",
            int'({leg1_low, leg2_low}), 1);
      vlow_fall = 1'b1; step(1); vlow_fall = 1'b0; step(10);  // R8 enter lockout
      check(!leg1_low && !leg2_low, "R8 lockout on falling flag",
            int'({leg1_low, leg2_low}), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule